// File: doc/BRIEF.md
# Accumulator Processor with Memory-Resident Working Registers

This block is a small hardwired 16-bit processor with one accumulator. Its three working registers are ordinary data words in its memory. The accumulator A is at word 0, the second operand B is at word 1, and the index IX is at word 2. Every instruction that uses them reads or writes memory through one synchronous single-port word store held inside the top. The program counter is 12 bits wide. Each instruction is fetched in two cycles and then runs a short fixed sequence of execute cycles chosen by its top four bits.

The surrounding environment preloads memory while reset is held, using a load/peek port. It then releases reset and waits for the halted output. After halt it reads the results back through the same port. A cycle counter, an instruction counter and the four condition flags are exposed so that timing and status can be observed. Programs are expected to start at word 3 or above.

Top module: `acc_cpu_top`

## Requirements
- R1: While rst_n is low, halted, cycle_cnt and instr_cnt read 0 and the load/peek port owns memory. After rst_n rises (two synchronizer cycles, then one cycle to load the start address), execution begins at start_pc. Word 0 is A, word 1 is B and word 2 is IX.
- R2: Instruction words carry the opcode in bits 15:12 and a target address in bits 11:0. The opcodes are: 0 add, 1 complement, 2 load-immediate, 3 move-indirect, 4 jump, 5 jump-if-zero, 6 jump-if-positive, 7 halt, 8 increment, 9 decrement, 10 and, 11 or, 12 shift-left, 13 shift-right, 14 copy-from-indexed, 15 copy-to-indexed. Each fetch takes two cycles, and instr_cnt rises by one for every fetched instruction, the halt included.
- R3: Add writes A+B into word 0. flag_v is set exactly when both operands have the same bit 15 and the sum's bit 15 differs. flag_c is the carry out of bit 15.
- R4: Complement (~A), and (A&B), or (A|B), shift-left (zero into bit 0) and logical shift-right (zero into bit 15) write word 0 and leave flag_v and flag_c unchanged.
- R5: Increment adds 0x0001 to A and decrement adds 0xFFFF to A. flag_v follows the same-sign rule of R3 with that addend, and flag_c is the carry out of that sum.
- R6: After any processor write to word 0, flag_z is 1 when the written value is zero and flag_s equals its bit 15.
- R7: Load-immediate stores the word that follows the instruction at the address in bits 11:0 and resumes execution after that word.
- R8: Move-indirect reads the following word as a pointer. It copies the word at the pointer's low 12 bits to the address in bits 11:0 and resumes after the pointer word.
- R9: Jump always loads PC from bits 11:0. Jump-if-zero does so only when word 0 is zero and otherwise falls through.
- R10: Jump-if-positive branches only when word 0 is nonzero with bit 15 clear. A zero or negative value falls through.
- R11: Copy-from-indexed writes M[M[2]] to M[bits 11:0]. Copy-to-indexed writes M[bits 11:0] to M[M[2]]. Both then store M[2]+1 into word 2.
- R12: Halt raises halted and keeps it high until reset, freezing PC and both counters. While halted, tb_rdata shows the word at tb_addr one cycle after the address is applied.
- R13: cycle_cnt counts every clock from the first fetch cycle up to the halt. Per instruction this is 2 cycles for halt, 3 for jump, 4 for load-immediate and the conditional jumps, 5 for ALU operations and move-indirect, and 6 for the indexed copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_pc | input | 12 | Address of the first instruction, taken as reset is released |
| halted | output | 1 | High once a halt instruction has run |
| tb_we | input | 1 | Write strobe of the load/peek port (honoured in reset or halt) |
| tb_addr | input | 12 | Word address of the load/peek port |
| tb_wdata | input | 16 | Data written through the load/peek port |
| tb_rdata | output | 16 | Registered read data of the memory |
| flag_z | output | 1 | Zero flag of the last value written to word 0 |
| flag_s | output | 1 | Sign flag of the last value written to word 0 |
| flag_v | output | 1 | Signed overflow of the last add, increment or decrement |
| flag_c | output | 1 | Carry out of the last add, increment or decrement |
| cycle_cnt | output | 32 | Clocks spent executing since reset |
| instr_cnt | output | 32 | Instructions fetched since reset |

## Verification
The arithmetic path is driven with operand pairs chosen to separate the flag rules. Same-sign sums that wrap set overflow. Mixed-sign sums that carry set carry but not overflow. Increment and decrement are run at 0x7FFF, 0xFFFF, 0x0000 and 0x8000, where the two flags diverge. The logic and shift operations use values with bit 15 and bit 0 set, which exposes a wrong fill bit or an arithmetic shift. The branches are run with A equal to zero, positive and negative, so that the zero test and the signed positive test cannot be mistaken for each other. The two-word and indexed instructions are checked by where the data lands, by where execution resumes, and by the value left in IX after back-to-back copies.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  // Opcode values are architectural: the program image depends on them.
  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 4'h0,
    OP_CMP   = 4'h1,
    OP_LDI   = 4'h2,
    OP_MOV   = 4'h3,
    OP_JMP   = 4'h4,
    OP_JZ    = 4'h5,
    OP_JPOS  = 4'h6,
    OP_HLT   = 4'h7,
    OP_INC   = 4'h8,
    OP_DEC   = 4'h9,
    OP_AND   = 4'hA,
    OP_OR    = 4'hB,
    OP_SHL   = 4'hC,
    OP_SHR   = 4'hD,
    OP_XFROM = 4'hE,
    OP_XTO   = 4'hF
  } opcode_e;

  typedef enum logic [4:0] {
    ST_BOOT,   // take start address
    ST_F1,     // issue instruction read, bump PC
    ST_F2,     // capture instruction, dispatch
    ST_RDA,    // issue read of word 0
    ST_RDB,    // latch A, issue read of word 1
    ST_WRA,    // combine, write word 0
    ST_BR,     // conditional branch decision on A
    ST_JMP,    // unconditional jump
    ST_IM1,    // issue read of the word after the opcode
    ST_IM2,    // store immediate word
    ST_PTR,    // issue read through pointer
    ST_IND,    // store indirect word
    ST_X1,     // issue read of IX
    ST_X2,     // latch IX, issue source read
    ST_X3,     // write destination
    ST_X4,     // write IX+1
    ST_HALT
  } state_e;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] store [DEPTH];
  logic [MEM_AW-1:0] idx;

  // Upper address bits alias onto the implemented depth.
  assign idx = MEM_AW'(addr);

  // Single port, read-before-write, one cycle read latency.
  always_ff @(posedge clk) begin
    if (we) begin
      store[idx] <= wdata;
    end
    rdata <= store[idx];
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              v,
  output logic              c,
  output logic              vc_upd
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   sum;

  always_comb begin
    case (op)
      OP_INC:  addend = DATA_W'(1);
      OP_DEC:  addend = '1;
      default: addend = b;
    endcase
    sum = {1'b0, a} + {1'b0, addend};
  end

  always_comb begin
    res    = a;
    v      = 1'b0;
    c      = 1'b0;
    vc_upd = 1'b0;
    case (op)
      OP_ADD, OP_INC, OP_DEC: begin
        res    = sum[DATA_W-1:0];
        v      = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);
        c      = sum[DATA_W];
        vc_upd = 1'b1;
      end
      OP_CMP:  res = ~a;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_SHL:  res = {a[MSB-1:0], 1'b0};
      OP_SHR:  res = {1'b0, a[MSB:1]};
      default: res = a;
    endcase
  end

  // R3: operands of opposite sign can never overflow.
  always_comb begin
    if (op == OP_ADD && (a[MSB] != b[MSB])) begin
      a_r3_mixed_sign_no_ovf: assert (!v);
    end
  end

  // R4: right shift is logical, bit 15 always filled with zero.
  always_comb begin
    if (op == OP_SHR) begin
      a_r4_shr_zero_fill: assert (!res[MSB]);
    end
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_pc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              bus_own,
  output logic              halted,
  output opcode_e           alu_op,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_v,
  input  logic              alu_c,
  input  logic              alu_vc,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_v,
  output logic              flag_c,
  output logic [CNT_W-1:0]  cycle_cnt,
  output logic [CNT_W-1:0]  instr_cnt
);

  localparam int MSB = DATA_W - 1;
  localparam logic [ADDR_W-1:0] A_LOC  = '0;
  localparam logic [ADDR_W-1:0] B_LOC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_LOC = ADDR_W'(2);

  state_e            state_q, state_n;
  logic [ADDR_W-1:0] pc_q, pc_n;
  logic [DATA_W-1:0] ir_q, ir_n;
  logic [DATA_W-1:0] opa_q, opa_n;
  logic [DATA_W-1:0] ix_q, ix_n;
  logic              z_q, z_n, s_q, s_n, v_q, v_n, c_q, c_n;
  logic [CNT_W-1:0]  cyc_q, cyc_n, ins_q, ins_n;

  opcode_e           opc;
  opcode_e           fetched_opc;
  logic [ADDR_W-1:0] dir;
  logic              br_take;
  logic              cyc_en;

  assign opc         = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);
  assign fetched_opc = opcode_e'(mem_rdata[DATA_W-1 -: OPC_W]);
  assign dir         = ir_q[ADDR_W-1:0];
  assign alu_op      = opc;
  assign alu_a       = opa_q;
  assign alu_b       = mem_rdata;

  // Conditional branch test on the freshly read word 0.
  always_comb begin
    if (opc == OP_JZ) begin
      br_take = (mem_rdata == '0);
    end else begin
      br_take = (mem_rdata != '0) && !mem_rdata[MSB];
    end
  end

  assign cyc_en = (state_q != ST_BOOT) && (state_q != ST_HALT);

  // Next-state and datapath control
  always_comb begin
    state_n   = state_q;
    pc_n      = pc_q;
    ir_n      = ir_q;
    opa_n     = opa_q;
    ix_n      = ix_q;
    z_n       = z_q;
    s_n       = s_q;
    v_n       = v_q;
    c_n       = c_q;
    ins_n     = ins_q;
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;

    case (state_q)
      ST_BOOT: begin
        pc_n    = start_pc;
        state_n = ST_F1;
      end
      ST_F1: begin
        mem_addr = pc_q;
        pc_n     = pc_q + 1'b1;
        state_n  = ST_F2;
      end
      ST_F2: begin
        ir_n  = mem_rdata;
        ins_n = ins_q + 1'b1;
        case (fetched_opc)
          OP_JMP:           state_n = ST_JMP;
          OP_LDI, OP_MOV:   state_n = ST_IM1;
          OP_XFROM, OP_XTO: state_n = ST_X1;
          OP_HLT:           state_n = ST_HALT;
          default:          state_n = ST_RDA;
        endcase
      end
      ST_RDA: begin
        mem_addr = A_LOC;
        state_n  = (opc == OP_JZ || opc == OP_JPOS) ? ST_BR : ST_RDB;
      end
      ST_RDB: begin
        mem_addr = B_LOC;
        opa_n    = mem_rdata;
        state_n  = ST_WRA;
      end
      ST_WRA: begin
        mem_addr  = A_LOC;
        mem_we    = 1'b1;
        mem_wdata = alu_res;
        if (alu_vc) begin
          v_n = alu_v;
          c_n = alu_c;
        end
        state_n = ST_F1;
      end
      ST_BR: begin
        if (br_take) begin
          pc_n = dir;
        end
        state_n = ST_F1;
      end
      ST_JMP: begin
        pc_n    = dir;
        state_n = ST_F1;
      end
      ST_IM1: begin
        mem_addr = pc_q;
        state_n  = (opc == OP_MOV) ? ST_PTR : ST_IM2;
      end
      ST_IM2: begin
        mem_addr  = dir;
        mem_we    = 1'b1;
        mem_wdata = mem_rdata;
        pc_n      = pc_q + 1'b1;
        state_n   = ST_F1;
      end
      ST_PTR: begin
        mem_addr = mem_rdata[ADDR_W-1:0];
        state_n  = ST_IND;
      end
      ST_IND: begin
        mem_addr  = dir;
        mem_we    = 1'b1;
        mem_wdata = mem_rdata;
        pc_n      = pc_q + 1'b1;
        state_n   = ST_F1;
      end
      ST_X1: begin
        mem_addr = IX_LOC;
        state_n  = ST_X2;
      end
      ST_X2: begin
        ix_n     = mem_rdata;
        mem_addr = (opc == OP_XFROM) ? mem_rdata[ADDR_W-1:0] : dir;
        state_n  = ST_X3;
      end
      ST_X3: begin
        mem_addr  = (opc == OP_XFROM) ? dir : ix_q[ADDR_W-1:0];
        mem_we    = 1'b1;
        mem_wdata = mem_rdata;
        state_n   = ST_X4;
      end
      ST_X4: begin
        mem_addr  = IX_LOC;
        mem_we    = 1'b1;
        mem_wdata = ix_q + 1'b1;
        state_n   = ST_F1;
      end
      ST_HALT: state_n = ST_HALT;
      default: state_n = ST_HALT;
    endcase

    // Z and S shadow whatever lands in word 0.
    if (mem_we && (mem_addr == A_LOC)) begin
      z_n = (mem_wdata == '0);
      s_n = mem_wdata[MSB];
    end

    cyc_n = cyc_en ? (cyc_q + 1'b1) : cyc_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      pc_q    <= '0;
      ir_q    <= '0;
      opa_q   <= '0;
      ix_q    <= '0;
      z_q     <= 1'b0;
      s_q     <= 1'b0;
      v_q     <= 1'b0;
      c_q     <= 1'b0;
      cyc_q   <= '0;
      ins_q   <= '0;
    end else begin
      state_q <= state_n;
      pc_q    <= pc_n;
      ir_q    <= ir_n;
      opa_q   <= opa_n;
      ix_q    <= ix_n;
      z_q     <= z_n;
      s_q     <= s_n;
      v_q     <= v_n;
      c_q     <= c_n;
      cyc_q   <= cyc_n;
      ins_q   <= ins_n;
    end
  end

  assign halted    = (state_q == ST_HALT);
  assign bus_own   = cyc_en;
  assign flag_z    = z_q;
  assign flag_s    = s_q;
  assign flag_v    = v_q;
  assign flag_c    = c_q;
  assign cycle_cnt = cyc_q;
  assign instr_cnt = ins_q;

  // R2: the fetch is always a pair of cycles.
  a_r2_fetch_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_F1) |=> (state_q == ST_F2));

  // R2: one instruction counted per capture.
  a_r2_instr_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_F2) |=> (instr_cnt == $past(instr_cnt) + 1'b1));

  // R6: flags follow the value written to word 0.
  a_r6_flags_track_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_addr == A_LOC)) |=>
      ((flag_z == ($past(mem_wdata) == '0)) && (flag_s == $past(mem_wdata[MSB]))));

  // R7: immediate load resumes after the data word.
  a_r7_skip_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IM2) |=> (pc_q == $past(pc_q) + 1'b1));

  // R9: jump-if-zero falls through on a nonzero A.
  a_r9_jz_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BR && opc == OP_JZ && mem_rdata != '0) |=> $stable(pc_q));

  // R10: zero or negative A never takes jump-if-positive.
  a_r10_jpos_nonpositive: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BR && opc == OP_JPOS && (mem_rdata[MSB] || mem_rdata == '0))
      |=> $stable(pc_q));

  // R12: halt is sticky and freezes PC.
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_q) && $stable(cycle_cnt)));

  // R13: every executing clock is counted.
  a_r13_cycle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && state_q != ST_BOOT) |=> (cycle_cnt == $past(cycle_cnt) + 1'b1));

endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_pc,
  output logic              halted,
  input  logic              tb_we,
  input  logic [ADDR_W-1:0] tb_addr,
  input  logic [DATA_W-1:0] tb_wdata,
  output logic [DATA_W-1:0] tb_rdata,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_v,
  output logic              flag_c,
  output logic [CNT_W-1:0]  cycle_cnt,
  output logic [CNT_W-1:0]  instr_cnt
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_s;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  logic [ADDR_W-1:0] cpu_addr, mem_addr;
  logic              cpu_we, mem_we;
  logic [DATA_W-1:0] cpu_wdata, mem_wdata, mem_rdata;
  logic              bus_own;
  opcode_e           alu_op;
  logic [DATA_W-1:0] alu_a, alu_b, alu_res;
  logic              alu_v, alu_c, alu_vc;

  // The processor owns the port while executing; otherwise the load/peek side.
  assign mem_addr  = bus_own ? cpu_addr  : tb_addr;
  assign mem_we    = bus_own ? cpu_we    : tb_we;
  assign mem_wdata = bus_own ? cpu_wdata : tb_wdata;
  assign tb_rdata  = mem_rdata;

  acc_cpu_mem #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .MEM_AW (MEM_AW)
  ) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  acc_cpu_alu #(
    .DATA_W (DATA_W)
  ) alu_i (
    .op     (alu_op),
    .a      (alu_a),
    .b      (alu_b),
    .res    (alu_res),
    .v      (alu_v),
    .c      (alu_c),
    .vc_upd (alu_vc)
  );

  acc_cpu_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_pc  (start_pc),
    .mem_addr  (cpu_addr),
    .mem_we    (cpu_we),
    .mem_wdata (cpu_wdata),
    .mem_rdata (mem_rdata),
    .bus_own   (bus_own),
    .halted    (halted),
    .alu_op    (alu_op),
    .alu_a     (alu_a),
    .alu_b     (alu_b),
    .alu_res   (alu_res),
    .alu_v     (alu_v),
    .alu_c     (alu_c),
    .alu_vc    (alu_vc),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .cycle_cnt (cycle_cnt),
    .instr_cnt (instr_cnt)
  );

  // R1: the processor never drives memory during reset.
  a_r1_no_bus_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_n_s) |-> !bus_own);

endmodule

// File: tb/acc_cpu_top_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_top_tb_top;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] start_pc;
  logic        halted;
  logic        tb_we;
  logic [11:0] tb_addr;
  logic [15:0] tb_wdata;
  logic [15:0] tb_rdata;
  logic        flag_z, flag_s, flag_v, flag_c;
  logic [31:0] cycle_cnt, instr_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] d;

  always #2 clk = ~clk;

  acc_cpu_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_pc  (start_pc),
    .halted    (halted),
    .tb_we     (tb_we),
    .tb_addr   (tb_addr),
    .tb_wdata  (tb_wdata),
    .tb_rdata  (tb_rdata),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .cycle_cnt (cycle_cnt),
    .instr_cnt (instr_cnt)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic        z;
    logic        s;
    logic        v;
    logic        c;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 16'h0003, 16'h0004, 16'h0007, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'h0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 1'b1, 1'b0},
    '{4'h0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'h0, 16'hFFFF, 16'h0002, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'h1, 16'h00FF, 16'h1234, 16'hFF00, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'h8, 16'h7FFF, 16'h0000, 16'h8000, 1'b0, 1'b1, 1'b1, 1'b0},
    '{4'h8, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'h9, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'h9, 16'h8000, 16'h0000, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'hA, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'hB, 16'hF0F0, 16'h0F00, 16'hFFF0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'hC, 16'hC001, 16'h0000, 16'h8002, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'hD, 16'h8002, 16'h0000, 16'h4001, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0:       return "R3";
      4'h8, 4'h9: return "R5";
      default:    return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] v);
    @(negedge clk);
    tb_we    = 1'b1;
    tb_addr  = a[11:0];
    tb_wdata = v;
    @(negedge clk);
    tb_we    = 1'b0;
  endtask

  task automatic peek(input int a, output logic [15:0] v);
    @(negedge clk);
    tb_addr = a[11:0];
    @(negedge clk);
    v = tb_rdata;
  endtask

  task automatic prep(input logic [11:0] sp);
    rst_n    = 1'b0;
    start_pc = sp;
    tb_we    = 1'b0;
    for (int i = 0; i < DEPTH; i++) wr(i, 16'h0000);
  endtask

  task automatic run();
    int w;
    @(negedge clk);
    rst_n = 1'b1;
    w = 0;
    while (!halted && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (!halted) begin
      n_tests++;
      n_fail++;
      $display("FAIL R12: halt not reached, actual halted=%0d expected 1", halted);
    end
  endtask

  // Conditional branch at word 3 to 0x010 (halt); fall-through increments A.
  task automatic branch_case(input logic [15:0] instr, input logic [15:0] a0,
                             input logic [15:0] exp, input string tag);
    prep(12'h003);
    wr(0, a0);
    wr(3, instr);
    wr(4, 16'h8000);
    wr(5, 16'h7000);
    wr(16'h10, 16'h7000);
    run();
    peek(0, d);
    chk(tag, d, exp);
  endtask

  initial begin
    rst_n    = 1'b0;
    tb_we    = 1'b0;
    tb_addr  = '0;
    tb_wdata = '0;
    start_pc = 12'h003;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 halted in reset", halted, 0);
    chk("R1 cycle_cnt in reset", cycle_cnt, 0);
    chk("R1 instr_cnt in reset", instr_cnt, 0);

    // ALU vector table: op at word 3, halt at word 4
    for (int k = 0; k < NV; k++) begin
      prep(12'h003);
      wr(0, VECS[k].a);
      wr(1, VECS[k].b);
      wr(3, {VECS[k].op, 12'h000});
      wr(4, 16'h7000);
      run();
      peek(0, d);
      chk({tag_of(VECS[k].op), " result"}, d, VECS[k].res);
      chk({tag_of(VECS[k].op), " v,c"}, {flag_v, flag_c}, {VECS[k].v, VECS[k].c});
      chk("R6 z,s after alu", {flag_z, flag_s}, {VECS[k].z, VECS[k].s});
    end

    // R1 start address, R13 halt cost, R12 sticky halt
    prep(12'h010);
    wr(3, 16'h8000);
    wr(16'h10, 16'h7000);
    run();
    peek(0, d);
    chk("R1 start_pc honoured", d, 16'h0000);
    chk("R13 halt-only cycles", cycle_cnt, 2);
    chk("R2 instr count halt-only", instr_cnt, 1);
    repeat (8) @(negedge clk);
    chk("R12 halted held", halted, 1);
    chk("R12 cycle_cnt frozen", cycle_cnt, 2);

    // R7 load-immediate into memory
    prep(12'h003);
    wr(3, 16'h2040);
    wr(4, 16'h1234);
    wr(5, 16'h7000);
    run();
    peek(16'h40, d);
    chk("R7 load stored", d, 16'h1234);
    chk("R7 data word skipped", instr_cnt, 2);
    chk("R13 load+halt cycles", cycle_cnt, 6);

    // R6 load-immediate into A, negative value
    prep(12'h003);
    wr(0, 16'h0005);
    wr(3, 16'h2000);
    wr(4, 16'h8001);
    wr(5, 16'h7000);
    run();
    peek(0, d);
    chk("R7 load into A", d, 16'h8001);
    chk("R6 z,s after load negative", {flag_z, flag_s}, 2'b01);

    // R6 load zero into A
    prep(12'h003);
    wr(0, 16'h0005);
    wr(3, 16'h2000);
    wr(4, 16'h0000);
    wr(5, 16'h7000);
    run();
    chk("R6 z,s after load zero", {flag_z, flag_s}, 2'b10);

    // R8 move-indirect, pointer upper bits ignored
    prep(12'h003);
    wr(16'h50, 16'hBEEF);
    wr(3, 16'h3060);
    wr(4, 16'hF050);
    wr(5, 16'h7000);
    run();
    peek(16'h60, d);
    chk("R8 move copied", d, 16'hBEEF);
    chk("R8 pointer word skipped", instr_cnt, 2);

    // R9 unconditional jump
    prep(12'h003);
    wr(0, 16'h0005);
    wr(3, 16'h4010);
    wr(4, 16'h8000);
    wr(5, 16'h7000);
    wr(16'h10, 16'h7000);
    run();
    peek(0, d);
    chk("R9 jump taken", d, 16'h0005);
    chk("R13 jump+halt cycles", cycle_cnt, 5);

    // R9 jump-if-zero
    branch_case(16'h5010, 16'h0000, 16'h0000, "R9 jz taken on zero");
    branch_case(16'h5010, 16'h0001, 16'h0002, "R9 jz falls on nonzero");

    // R10 jump-if-positive
    branch_case(16'h6010, 16'h0005, 16'h0005, "R10 jpos taken on positive");
    branch_case(16'h6010, 16'h0000, 16'h0001, "R10 jpos falls on zero");
    branch_case(16'h6010, 16'h8000, 16'h8001, "R10 jpos falls on negative");
    chk("R13 branch+inc+halt cycles", cycle_cnt, 11);

    // R11 copy-from-indexed twice
    prep(12'h003);
    wr(2, 16'h0030);
    wr(16'h30, 16'hAAAA);
    wr(16'h31, 16'h5555);
    wr(3, 16'hE040);
    wr(4, 16'hE041);
    wr(5, 16'h7000);
    run();
    peek(16'h40, d);
    chk("R11 from-indexed first", d, 16'hAAAA);
    peek(16'h41, d);
    chk("R11 from-indexed second", d, 16'h5555);
    peek(2, d);
    chk("R11 IX advanced by two", d, 16'h0032);
    chk("R13 two copies+halt cycles", cycle_cnt, 14);

    // R11 copy-to-indexed twice
    prep(12'h003);
    wr(2, 16'h0070);
    wr(16'h44, 16'h1357);
    wr(3, 16'hF044);
    wr(4, 16'hF044);
    wr(5, 16'h7000);
    run();
    peek(16'h70, d);
    chk("R11 to-indexed first", d, 16'h1357);
    peek(16'h71, d);
    chk("R11 to-indexed second", d, 16'h1357);
    peek(16'h72, d);
    chk("R11 to-indexed no extra write", d, 16'h0000);
    peek(2, d);
    chk("R11 IX after to-indexed", d, 16'h0072);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule